// File: doc/BRIEF.md
# Zero-Crossing Stepped Digital Volume

This block sits in the playback path just ahead of the D/A converter. It scales each signed 16-bit audio sample by one of 32 gain settings spaced 1.5 dB apart, from +12 dB at the top code down to -34.5 dB at the bottom code. A control register drives the requested gain code into the block.

A change of code is not applied at once. It is held as pending until the sample stream crosses zero, so the level step does not produce an audible click. If no crossing shows up within 256 frame strobes after the request, the pending gain is forced in anyway. A newer request replaces an older pending one and restarts that wait.

The scaled sample leaves the block one clock after the input sample. Results that fall outside the signed 16-bit range are clamped rather than wrapped.

Top module: `zc_volume`

## Requirements
- R1: After reset the applied code is 8 (0 dB). Nothing is pending. `smp_valid_o` is low and `smp_o` is zero. A sample sent at code 8 with no change pending comes out unchanged.
- R2: Code c selects the coefficient `base[c mod 4] >> (c / 4)`, with base = {16384, 13785, 11599, 9759}, in unsigned Q4.12. Code 0 is +12 dB and code 31 is -34.5 dB.
- R3: `smp_o` equals floor(sample × coefficient / 4096). `smp_valid_o` is high exactly in the cycle after `smp_valid_i` was high.
- R4: A result above 32767 gives 32767, and a result below -32768 gives -32768.
- R5: A `gain_code_i` value that differs from the latest request is registered as a new request. Samples from the following cycle onward that are not zero crossings keep using the previously applied code.
- R6: A valid sample is a zero crossing when it equals zero, or when its sign bit differs from the sign bit of the previous valid sample. The previous sign after reset counts as positive. A crossing sample with a change pending is itself scaled by the new code, and that code stays applied afterwards.
- R7: Frame strobes on `frame_i` are counted while a change is pending. On the 256th strobe after the request, the new code is applied even without a crossing. A sample valid in that same cycle already uses the new code.
- R8: A new request arriving while another is pending replaces the target and restarts the 256-strobe count from zero.
- R9: A request back to the currently applied code cancels the pending change. Later strobes then never force the abandoned code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe per audio frame |
| smp_valid_i | input | 1 | Input sample valid |
| smp_i | input | 16 | Signed input sample |
| gain_code_i | input | 5 | Requested gain code from the volume register |
| smp_valid_o | output | 1 | Scaled sample valid |
| smp_o | output | 16 | Signed scaled, saturated sample |

## Verification
The bench builds the block with its default parameters: a 16-bit sample, a 5-bit code and a 256-frame timeout. At these values all 32 coefficients can be swept, and the full forced-update window, including a restarted one, fits in a few thousand cycles. Runs of same-sign samples keep a change pending long enough to hit the timeout exactly on its 256th strobe. Strobes without samples, and samples without strobes, show that only strobes advance the wait.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int unsigned COEF_W    = 15;
  localparam int unsigned FRAC_W    = 12;
  localparam int unsigned OCT_STEPS = 4;

  // one 6 dB octave at +12 dB, Q4.12; lower codes shift right per octave
  function automatic logic [COEF_W-1:0] octave_base(int unsigned r);
    case (r)
      0:       return COEF_W'(16384);
      1:       return COEF_W'(13785);
      2:       return COEF_W'(11599);
      default: return COEF_W'(9759);
    endcase
  endfunction

  function automatic logic [COEF_W-1:0] coef_of(int unsigned code);
    int unsigned k;
    k = code / OCT_STEPS;
    if (k >= COEF_W) return '0;
    return octave_base(code % OCT_STEPS) >> k;
  endfunction
endpackage

// File: rtl/vol_zc_det.sv
module vol_zc_det #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic              zc_o
);
  logic prev_neg_q;
  logic is_zero;
  logic sign_flip;

  assign is_zero   = (smp_i == '0);
  assign sign_flip = smp_i[DATA_W-1] ^ prev_neg_q;
  assign zc_o      = valid_i & (is_zero | sign_flip);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_neg_q <= 1'b0;
    else if (valid_i) prev_neg_q <= smp_i[DATA_W-1];
  end

  p_no_zc_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !zc_o);
endmodule

// File: rtl/vol_req_ctrl.sv
module vol_req_ctrl #(
  parameter int unsigned CODE_W         = 5,
  parameter int unsigned TIMEOUT_FRAMES = 256,
  parameter int unsigned UNITY_CODE     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              zc_i,
  input  logic [CODE_W-1:0] gain_code_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_FRAMES - 1);

  logic [CODE_W-1:0] tgt_q, app_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend, req_new, expire, apply_now;

  assign pend      = (tgt_q != app_q);
  assign req_new   = (gain_code_i != tgt_q);
  assign expire    = frame_i & (cnt_q == CNT_LAST);
  assign apply_now = pend & (zc_i | expire);
  assign code_o    = apply_now ? tgt_q : app_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= CODE_W'(UNITY_CODE);
      app_q <= CODE_W'(UNITY_CODE);
      cnt_q <= '0;
    end else begin
      if (apply_now) app_q <= tgt_q;
      if (req_new) begin
        tgt_q <= gain_code_i;
        cnt_q <= '0;
      end else if (apply_now) begin
        cnt_q <= '0;
      end else if (frame_i && pend) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zc_i && !frame_i) |=> $stable(app_q));
  p_zc_apply_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && zc_i) |=> (app_q == $past(tgt_q)));
  p_timeout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && frame_i && cnt_q == CNT_LAST) |=> (app_q == $past(tgt_q)));
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_new |=> (cnt_q == '0 && tgt_q == $past(gain_code_i)));
  p_idle_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend && !req_new) |=> $stable(cnt_q));
endmodule

// File: rtl/vol_coef_rom.sv
module vol_coef_rom
  import vol_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [COEF_W-1:0] coef_o
);
  localparam int unsigned DEPTH = 2 ** CODE_W;

  logic [COEF_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign rom[i] = coef_of(i);
  end

  assign coef_o = rom[code_i];
endmodule

// File: rtl/vol_scaler.sv
module vol_scaler
  import vol_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] smp_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W + 1;
  localparam logic signed [PROD_W-1:0] SAT_MAX = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_MIN = -PROD_W'(64'sd1 <<< (DATA_W - 1));

  logic signed [PROD_W-1:0] a_ext, b_ext, prod, shifted;
  logic [DATA_W-1:0]        clamped;
  logic                     hi, lo;

  assign a_ext   = {{(PROD_W-DATA_W){smp_i[DATA_W-1]}}, smp_i};
  assign b_ext   = {{(PROD_W-COEF_W){1'b0}}, coef_i};
  assign prod    = a_ext * b_ext;
  assign shifted = prod >>> FRAC_W;
  assign hi      = shifted > SAT_MAX;
  assign lo      = shifted < SAT_MIN;

  always_comb begin
    if (hi)      clamped = SAT_MAX[DATA_W-1:0];
    else if (lo) clamped = SAT_MIN[DATA_W-1:0];
    else         clamped = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      smp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) smp_o <= clamped;
    end
  end

  p_sat_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prod > (SAT_MAX <<< FRAC_W) + ((64'sd1 <<< FRAC_W) - 1))
      |=> (smp_o == {1'b0, {(DATA_W-1){1'b1}}}));
  p_sat_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prod < (SAT_MIN <<< FRAC_W)) |=> (smp_o == {1'b1, {(DATA_W-1){1'b0}}}));
endmodule

// File: rtl/zc_volume.sv
module zc_volume
  import vol_pkg::*;
#(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned CODE_W         = 5,
  parameter int unsigned TIMEOUT_FRAMES = 256,
  parameter int unsigned UNITY_CODE     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [CODE_W-1:0] gain_code_i,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_o
);
  logic              zc;
  logic [CODE_W-1:0] code_eff;
  logic [COEF_W-1:0] coef;

  vol_zc_det #(.DATA_W(DATA_W)) u_zc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .smp_i   (smp_i),
    .zc_o    (zc)
  );

  vol_req_ctrl #(
    .CODE_W         (CODE_W),
    .TIMEOUT_FRAMES (TIMEOUT_FRAMES),
    .UNITY_CODE     (UNITY_CODE)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame_i),
    .zc_i        (zc),
    .gain_code_i (gain_code_i),
    .code_o      (code_eff)
  );

  vol_coef_rom #(.CODE_W(CODE_W)) u_rom (
    .code_i (code_eff),
    .coef_o (coef)
  );

  vol_scaler #(.DATA_W(DATA_W)) u_scl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .smp_i   (smp_i),
    .coef_i  (coef),
    .valid_o (smp_valid_o),
    .smp_o   (smp_o)
  );

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> smp_valid_o);
  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !smp_valid_o);
endmodule

// File: tb/tb_zc_volume.sv
`timescale 1ns/1ps
module tb_zc_volume;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] smp = '0;
  logic [4:0]  code = 5'd8;
  logic        vld_o;
  logic [15:0] smp_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  zc_volume dut (
    .clk_i (clk), .rst_ni (rst_n), .frame_i (frame), .smp_valid_i (vld),
    .smp_i (smp), .gain_code_i (code), .smp_valid_o (vld_o), .smp_o (smp_o)
  );

  // reference model state
  int m_app = 8, m_tgt = 8, m_cnt = 0;
  bit m_prev_neg = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  function automatic int coef_ref(int c);
    int base[4] = '{16384, 13785, 11599, 9759};
    return base[c % 4] >> (c / 4);
  endfunction

  function automatic logic [15:0] scale_ref(logic [15:0] s, int c);
    longint p;
    p = longint'($signed(s)) * coef_ref(c);
    p = p >>> 12;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(int g, bit f, bit v, logic [15:0] s, string tag);
    bit pend, zc, apply;
    int eff;
    @(negedge clk);
    code = 5'(g); frame = f; vld = v; smp = s;
    pend  = (m_tgt != m_app);
    zc    = v && (s == 16'h0 || s[15] != m_prev_neg);
    apply = pend && (zc || (f && m_cnt == 255));
    eff   = apply ? m_tgt : m_app;
    if (v) begin
      exp_q.push_back(scale_ref(s, eff));
      tag_q.push_back(tag);
    end
    if (apply) m_app = m_tgt;
    if (g != m_tgt) begin
      m_tgt = g; m_cnt = 0;
    end else if (apply) begin
      m_cnt = 0;
    end else if (f && pend) begin
      m_cnt++;
    end
    if (v) m_prev_neg = s[15];
  endtask

  task automatic idle();
    @(negedge clk);
    frame = 1'b0; vld = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && vld_o) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R3 unexpected output act=%0h exp=none", smp_o);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(smp_o), 32'(e));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid at reset", 32'(vld_o), 32'd0);
    chk("R1 data at reset", 32'(smp_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(vld_o), 32'd0);

    // R1: unity at code 8
    drive(8, 1, 1, 16'd1234, "R1");
    drive(8, 1, 1, 16'd20000, "R1");
    idle();

    // R2/R3: coefficient sweep; zero sample crosses, applies new code
    for (int c = 0; c < 32; c++) begin
      drive(c, 0, 0, 16'd0, "R5");
      drive(c, 1, 1, 16'd0, "R6");
      drive(c, 1, 1, 16'd5000, "R2");
      drive(c, 1, 1, -16'sd7001, "R3");
      drive(c, 1, 1, -16'sd3, "R3");
    end
    idle();

    // R4: saturation at +12 dB
    drive(0, 0, 0, 16'd0, "R4");
    drive(0, 1, 1, 16'd0, "R4");
    drive(0, 1, 1, 16'd30000, "R4");
    drive(0, 1, 1, 16'd8192, "R4");
    drive(0, 1, 1, -16'sd30000, "R4");
    drive(0, 1, 1, -16'sd8192, "R4");
    drive(0, 1, 1, 16'h8000, "R4");

    // back to unity via crossing
    drive(8, 0, 0, 16'd0, "R5");
    drive(8, 1, 1, 16'd100, "R6");
    drive(8, 1, 1, 16'd200, "R5");

    // R5/R6: deferral until sign flip
    drive(12, 0, 0, 16'd0, "R5");
    for (int i = 0; i < 10; i++) drive(12, 1, 1, 16'(1000 + i), "R5");
    drive(12, 1, 1, -16'sd1000, "R6");
    drive(12, 1, 1, -16'sd1000, "R6");

    // R7: forced after 256 strobes, negative run; gaps and sample-only cycles
    drive(4, 0, 0, 16'd0, "R7");
    for (int i = 0; i < 100; i++) drive(4, 1, 0, 16'd0, "R7");
    for (int i = 0; i < 20; i++) drive(4, 0, 1, -16'sd4000, "R7");
    for (int i = 0; i < 170; i++) drive(4, 1, 1, -16'sd4000, "R7");

    // R8: replacement restarts the count
    drive(20, 0, 0, 16'd0, "R8");
    for (int i = 0; i < 200; i++) drive(20, 1, 1, -16'sd9000, "R8");
    drive(16, 0, 0, 16'd0, "R8");
    for (int i = 0; i < 270; i++) drive(16, 1, 1, -16'sd9000, "R8");

    // R9: request back to applied cancels
    drive(2, 0, 0, 16'd0, "R9");
    for (int i = 0; i < 50; i++) drive(2, 1, 1, -16'sd9000, "R9");
    drive(16, 0, 0, 16'd0, "R9");
    for (int i = 0; i < 300; i++) drive(16, 1, 1, -16'sd9000, "R9");
    drive(16, 1, 1, 16'd9000, "R9");

    idle();
    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule